// File: doc/BRIEF.md
# Ethernet MAC Flow Control Unit

This block provides link-level flow control for a 10/100 Ethernet MAC. On a full-duplex link it asks the transmitter to send pause frames, either because software forces one with a zero or maximum pause time or because the receive buffer crosses its high or low watermark. It also follows pause frames arriving from the link partner. A 16-bit timer counts the received pause time down in 512-bit-time slots, and the transmitter is held off while that timer runs and the master enable is set. On a half-duplex link it asks for a jam pattern when a frame starts to arrive while the receive buffer is above a back-pressure watermark. That request can follow every frame, or only frames whose destination address matched.

Software reaches the block through one control/status byte with bit positions of its own: [0] force-zero pause, [1] force-max pause, [2] automatic watermark pause enable, [3] back pressure on any frame, [4] back pressure on destination match only, [5] received-pause status (write 1 to clear), [6] pause-active (read-only), [7] master flow-control enable. Writes store bits 0–4 and 7, bit 5 clears on a written 1, and bit 6 ignores writes. The read data port always shows the current byte.

Pause requests are served by a state machine with states PQ_IDLE, PQ_FZERO (forced zero time), PQ_FMAX (forced maximum time), PQ_AZERO (watermark zero time) and PQ_AMAX (watermark maximum time). From PQ_IDLE it moves to the first pending source in this priority: forced zero, forced max, watermark zero, watermark max. Each serving state returns to PQ_IDLE on the transmitter's done strobe, and that clears the source it served.

Top module: `eth_flowctl`

## Requirements
- R1: After reset, reg_rdata is 0x00 and txp_req, jam_req and tx_inhibit are 0.
- R2: Writing 1 to bit 0 raises txp_req with txp_time 0x0000 on the second rising edge after the write cycle. Bit 0 reads back 0 after the edge on which txp_done is seen.
- R3: Writing 1 to bit 1 raises txp_req with txp_time 0xFFFF, and bit 1 clears itself on txp_done in the same way.
- R4: With bits 0 and 1 both set, the zero-time request is served first and then the maximum-time request. txp_req and txp_time stay stable from the start of a request until its txp_done.
- R5: With bit 2 set and full_duplex high, fill_level rising above hi_mark produces exactly one 0xFFFF request. It falling below lo_mark afterwards produces exactly one 0x0000 request. Levels in between, or repeated excursions on the same side, produce none.
- R6: With bit 3 set and full_duplex low, a rx_frame_start while fill_level > bp_mark pulses jam_req for one cycle on the next cycle. Below the mark, or on a full-duplex link, there is no pulse.
- R7: With only bit 4 set, jam_req follows the R6 rule but also requires rx_da_match high together with rx_frame_start.
- R8: Bit 5 is set by rx_pause_vld while full_duplex is high, and not while it is low. Writing a 1 to bit 5 clears it.
- R9: A reg_rd pulse clears bit 5 when rd_clr_off is 0 and leaves it set when rd_clr_off is 1.
- R10: A full-duplex rx_pause_vld loads rx_pause_time into the pause timer, which drops by one per slot_tick. Bit 6 reads 1 while the timer is nonzero. A new pause reloads the timer, and a zero time clears bit 6 on the next cycle.
- R11: tx_inhibit is 1 exactly when bit 7 is set and bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_rd | input | 1 | Control byte read strobe (may clear bit 5) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control/status byte |
| rd_clr_off | input | 1 | 1 disables clear-on-read of bit 5 |
| full_duplex | input | 1 | Link is full duplex |
| fill_level | input | LVL_W | Receive buffer fill level |
| hi_mark | input | LVL_W | Pause high watermark |
| lo_mark | input | LVL_W | Pause low watermark |
| bp_mark | input | LVL_W | Back-pressure watermark |
| rx_pause_vld | input | 1 | A pause frame was received |
| rx_pause_time | input | TIME_W | Pause time of the received frame |
| slot_tick | input | 1 | One pulse per 512 bit times |
| rx_frame_start | input | 1 | Start of an incoming frame |
| rx_da_match | input | 1 | Destination address of that frame matched |
| txp_req | output | 1 | Pause frame request to the transmitter |
| txp_time | output | TIME_W | Pause time to send |
| txp_done | input | 1 | Transmitter finished the requested pause frame |
| jam_req | output | 1 | Jam pattern request, one-cycle pulse |
| tx_inhibit | output | 1 | Hold off the transmitter |

## Verification
Register bits, pause-active and tx_inhibit change on the rising edge that captures the stimulus, so the bench samples them one time step after that edge. jam_req follows a frame start by exactly one edge and is sampled in the cycle after the strobe drops. A pause request appears on the second edge after the write or watermark crossing. The bench's transmitter model therefore watches txp_req on every falling edge and matches each new request, in order, against a queue of expected pause times filled by the stimulus tasks. It answers with txp_done three cycles later, and any queue left over at the end of a section counts as a failure.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [2:0] {
        PQ_IDLE,
        PQ_FZERO,
        PQ_FMAX,
        PQ_AZERO,
        PQ_AMAX
    } preq_state_t;

    localparam int CB_FZERO  = 0;
    localparam int CB_FMAX   = 1;
    localparam int CB_AUTO   = 2;
    localparam int CB_BPANY  = 3;
    localparam int CB_BPDA   = 4;
    localparam int CB_SEEN   = 5;
    localparam int CB_ACTIVE = 6;
    localparam int CB_EN     = 7;
endpackage

// File: rtl/fc_pause_req.sv
module fc_pause_req
    import fc_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int LVL_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_zero,
    input  logic              force_max,
    input  logic              auto_en,
    input  logic              full_duplex,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [LVL_W-1:0]  hi_mark,
    input  logic [LVL_W-1:0]  lo_mark,
    input  logic              txp_done,
    output logic              txp_req,
    output logic [TIME_W-1:0] txp_time,
    output logic              clr_fzero,
    output logic              clr_fmax
);
    localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

    preq_state_t state, next;
    logic        above_hi, pend_max, pend_zero;
    logic        auto_on;

    assign auto_on = auto_en & full_duplex;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PQ_IDLE;
        else        state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            PQ_IDLE: begin
                if (force_zero)     next = PQ_FZERO;
                else if (force_max) next = PQ_FMAX;
                else if (pend_zero) next = PQ_AZERO;
                else if (pend_max)  next = PQ_AMAX;
            end
            PQ_FZERO, PQ_FMAX, PQ_AZERO, PQ_AMAX: begin
                if (txp_done) next = PQ_IDLE;
            end
            default: next = PQ_IDLE;
        endcase
    end

    always_comb begin
        txp_req   = (state != PQ_IDLE);
        txp_time  = (state == PQ_FMAX || state == PQ_AMAX) ? TIME_MAX : '0;
        clr_fzero = (state == PQ_FZERO) && txp_done;
        clr_fmax  = (state == PQ_FMAX) && txp_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !auto_on) begin
            above_hi  <= 1'b0;
            pend_max  <= 1'b0;
            pend_zero <= 1'b0;
        end else begin
            if (state == PQ_IDLE && next == PQ_AZERO) pend_zero <= 1'b0;
            if (state == PQ_IDLE && next == PQ_AMAX)  pend_max  <= 1'b0;
            if (!above_hi && fill_level > hi_mark) begin
                above_hi  <= 1'b1;
                pend_max  <= 1'b1;
                pend_zero <= 1'b0;
            end else if (above_hi && fill_level < lo_mark) begin
                above_hi  <= 1'b0;
                pend_zero <= 1'b1;
                pend_max  <= 1'b0;
            end
        end
    end

    // R4: a request holds still until the transmitter reports it sent
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (txp_req && !txp_done) |=> (txp_req && $stable(txp_time)));

    // R4: forced zero wins over every other pending source
    p_zero_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PQ_IDLE && force_zero) |=> (txp_req && txp_time == '0));

    // R5: a high crossing leads to a pending or served maximum-time pause
    p_auto_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && !above_hi && fill_level > hi_mark) |=> (pend_max || txp_req));
endmodule

// File: rtl/fc_pause_timer.sv
module fc_pause_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pause_vld,
    input  logic              full_duplex,
    input  logic [TIME_W-1:0] pause_time,
    input  logic              slot_tick,
    output logic              active
);
    logic [TIME_W-1:0] cnt;
    logic              load;

    assign load   = pause_vld & full_duplex;
    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (load)                    cnt <= pause_time;
        else if (slot_tick && cnt != '0)  cnt <= cnt - TIME_W'(1);
    end

    // R10: one slot per tick while running
    p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && slot_tick && cnt != '0) |=> (cnt == $past(cnt) - TIME_W'(1)));

    // R10: a zero pause time releases at once
    p_zero_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && pause_time == '0) |=> !active);
endmodule

// File: rtl/fc_backpress.sv
module fc_backpress #(
    parameter int LVL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex,
    input  logic             bp_any,
    input  logic             bp_da,
    input  logic             frame_start,
    input  logic             da_match,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] bp_mark,
    output logic             jam_req
);
    logic hit;

    assign hit = !full_duplex && frame_start && (fill_level > bp_mark) &&
                 (bp_any || (bp_da && da_match));

    always_ff @(posedge clk) begin
        if (!rst_n) jam_req <= 1'b0;
        else        jam_req <= hit;
    end

    // R6: jam only follows a half-duplex frame start
    p_jam_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req |-> $past(!full_duplex && frame_start));

    // R7: without the any-frame mode a jam needs a matching address
    p_jam_da_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_req && !$past(bp_any)) |-> $past(da_match));
endmodule

// File: rtl/eth_flowctl.sv
module eth_flowctl
    import fc_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int LVL_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rd_clr_off,
    input  logic              full_duplex,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [LVL_W-1:0]  hi_mark,
    input  logic [LVL_W-1:0]  lo_mark,
    input  logic [LVL_W-1:0]  bp_mark,
    input  logic              rx_pause_vld,
    input  logic [TIME_W-1:0] rx_pause_time,
    input  logic              slot_tick,
    input  logic              rx_frame_start,
    input  logic              rx_da_match,
    output logic              txp_req,
    output logic [TIME_W-1:0] txp_time,
    input  logic              txp_done,
    output logic              jam_req,
    output logic              tx_inhibit
);
    logic ctl_fz, ctl_fm, ctl_auto, ctl_bpa, ctl_bpd, ctl_en, rx_seen;
    logic clr_fzero, clr_fmax, pause_active;
    logic unused_wbit;

    assign unused_wbit = reg_wdata[CB_ACTIVE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_fz   <= 1'b0;
            ctl_fm   <= 1'b0;
            ctl_auto <= 1'b0;
            ctl_bpa  <= 1'b0;
            ctl_bpd  <= 1'b0;
            ctl_en   <= 1'b0;
        end else if (reg_wr) begin
            ctl_fz   <= reg_wdata[CB_FZERO];
            ctl_fm   <= reg_wdata[CB_FMAX];
            ctl_auto <= reg_wdata[CB_AUTO];
            ctl_bpa  <= reg_wdata[CB_BPANY];
            ctl_bpd  <= reg_wdata[CB_BPDA];
            ctl_en   <= reg_wdata[CB_EN];
        end else begin
            if (clr_fzero) ctl_fz <= 1'b0;
            if (clr_fmax)  ctl_fm <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_seen <= 1'b0;
        else if (rx_pause_vld && full_duplex)
            rx_seen <= 1'b1;
        else if ((reg_wr && reg_wdata[CB_SEEN]) || (reg_rd && !rd_clr_off))
            rx_seen <= 1'b0;
    end

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[CB_FZERO]  = ctl_fz;
        reg_rdata[CB_FMAX]   = ctl_fm;
        reg_rdata[CB_AUTO]   = ctl_auto;
        reg_rdata[CB_BPANY]  = ctl_bpa;
        reg_rdata[CB_BPDA]   = ctl_bpd;
        reg_rdata[CB_SEEN]   = rx_seen;
        reg_rdata[CB_ACTIVE] = pause_active;
        reg_rdata[CB_EN]     = ctl_en;
    end

    assign tx_inhibit = ctl_en & pause_active;

    fc_pause_req #(.TIME_W(TIME_W), .LVL_W(LVL_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_zero  (ctl_fz),
        .force_max   (ctl_fm),
        .auto_en     (ctl_auto),
        .full_duplex (full_duplex),
        .fill_level  (fill_level),
        .hi_mark     (hi_mark),
        .lo_mark     (lo_mark),
        .txp_done    (txp_done),
        .txp_req     (txp_req),
        .txp_time    (txp_time),
        .clr_fzero   (clr_fzero),
        .clr_fmax    (clr_fmax)
    );

    fc_pause_timer #(.TIME_W(TIME_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pause_vld   (rx_pause_vld),
        .full_duplex (full_duplex),
        .pause_time  (rx_pause_time),
        .slot_tick   (slot_tick),
        .active      (pause_active)
    );

    fc_backpress #(.LVL_W(LVL_W)) u_bp (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_duplex (full_duplex),
        .bp_any      (ctl_bpa),
        .bp_da       (ctl_bpd),
        .frame_start (rx_frame_start),
        .da_match    (rx_da_match),
        .fill_level  (fill_level),
        .bp_mark     (bp_mark),
        .jam_req     (jam_req)
    );

    // R8: a full-duplex pause arrival is visible in the status byte next cycle
    p_seen_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_vld && full_duplex) |=> reg_rdata[CB_SEEN]);

    // R2: a forced zero bit is only dropped by software or a served request
    p_fz_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fz && !reg_wr && !(txp_req && txp_done)) |=> ctl_fz);
endmodule

// File: tb/test_eth_flowctl.sv
module test_eth_flowctl;
    localparam int TW = 16;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n, reg_wr, reg_rd, rd_clr_off, full_duplex;
    logic [7:0]    reg_wdata, reg_rdata;
    logic [LW-1:0] fill_level, hi_mark, lo_mark, bp_mark;
    logic          rx_pause_vld, slot_tick, rx_frame_start, rx_da_match;
    logic [TW-1:0] rx_pause_time, txp_time;
    logic          txp_req, txp_done, jam_req, tx_inhibit;

    int            n_chk = 0;
    int            n_fail = 0;
    logic [TW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    eth_flowctl #(.TIME_W(TW), .LVL_W(LW)) i_eth_flowctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_clr_off(rd_clr_off),
        .full_duplex(full_duplex), .fill_level(fill_level), .hi_mark(hi_mark),
        .lo_mark(lo_mark), .bp_mark(bp_mark), .rx_pause_vld(rx_pause_vld),
        .rx_pause_time(rx_pause_time), .slot_tick(slot_tick),
        .rx_frame_start(rx_frame_start), .rx_da_match(rx_da_match),
        .txp_req(txp_req), .txp_time(txp_time), .txp_done(txp_done),
        .jam_req(jam_req), .tx_inhibit(tx_inhibit)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_req(logic [TW-1:0] t, string tag);
        exp_q.push_back(t);
        tag_q.push_back(tag);
    endtask

    task automatic wr_reg(logic [7:0] v);
        @(posedge clk); #1 reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(posedge clk); #1 reg_rd = 1'b1;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic pause_rx(logic [TW-1:0] t);
        @(posedge clk); #1 rx_pause_vld = 1'b1; rx_pause_time = t;
        @(posedge clk); #1 rx_pause_vld = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1 slot_tick = 1'b1;
        @(posedge clk); #1 slot_tick = 1'b0;
    endtask

    task automatic frame(logic da);
        @(posedge clk); #1 rx_frame_start = 1'b1; rx_da_match = da;
        @(posedge clk); #1 rx_frame_start = 1'b0; rx_da_match = 1'b0;
    endtask

    // Transmitter model and scoreboard monitor
    initial begin
        int hold;
        hold = 0;
        txp_done = 1'b0;
        forever begin
            @(negedge clk);
            if (hold > 0) begin
                hold--;
                if (hold == 0) txp_done = 1'b1;
            end else if (txp_done) begin
                txp_done = 1'b0;
            end else if (txp_req) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected pause request", 32'(txp_time), 32'hDEAD);
                end else begin
                    chk(tag_q.pop_front(), 32'(txp_time), 32'(exp_q.pop_front()));
                end
                hold = 3;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        rd_clr_off = 1'b0; full_duplex = 1'b0;
        fill_level = 12'd50; hi_mark = 12'd100; lo_mark = 12'd20; bp_mark = 12'd40;
        rx_pause_vld = 1'b0; rx_pause_time = '0; slot_tick = 1'b0;
        rx_frame_start = 1'b0; rx_da_match = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reg_rdata", 32'(reg_rdata), 32'h00);
        chk("R1 txp_req", 32'(txp_req), 0);
        chk("R1 jam_req", 32'(jam_req), 0);
        chk("R1 tx_inhibit", 32'(tx_inhibit), 0);

        expect_req(16'h0000, "R2 forced zero time");
        wr_reg(8'h01);
        cyc(12);
        chk("R2 force-zero bit cleared", 32'(reg_rdata[0]), 0);

        expect_req(16'hFFFF, "R3 forced max time");
        wr_reg(8'h02);
        cyc(12);
        chk("R3 force-max bit cleared", 32'(reg_rdata[1]), 0);

        expect_req(16'h0000, "R4 zero served first");
        expect_req(16'hFFFF, "R4 max served second");
        wr_reg(8'h03);
        cyc(20);
        chk("R4 both force bits cleared", 32'(reg_rdata[1:0]), 0);
        chk("R4 all requests served", exp_q.size(), 0);

        full_duplex = 1'b1;
        wr_reg(8'h04);
        cyc(4);
        expect_req(16'hFFFF, "R5 high crossing max time");
        fill_level = 12'd120;
        cyc(12);
        fill_level = 12'd60;
        cyc(5);
        fill_level = 12'd110;
        cyc(8);
        chk("R5 no repeat while above", exp_q.size(), 0);
        expect_req(16'h0000, "R5 low crossing zero time");
        fill_level = 12'd10;
        cyc(12);
        fill_level = 12'd60;
        cyc(8);
        chk("R5 exactly one request per crossing", exp_q.size(), 0);

        wr_reg(8'h80);
        pause_rx(16'd3);
        chk("R10 active after load", 32'(reg_rdata[6]), 1);
        chk("R11 inhibit while paused", 32'(tx_inhibit), 1);
        chk("R8 status set in full duplex", 32'(reg_rdata[5]), 1);
        tick(); tick();
        chk("R10 still active after two slots", 32'(reg_rdata[6]), 1);
        tick();
        chk("R10 released after three slots", 32'(reg_rdata[6]), 0);
        chk("R11 inhibit released", 32'(tx_inhibit), 0);
        pause_rx(16'd5);
        tick();
        pause_rx(16'd2);
        tick();
        chk("R10 reload keeps running", 32'(reg_rdata[6]), 1);
        tick();
        chk("R10 reload expired on new time", 32'(reg_rdata[6]), 0);
        pause_rx(16'd10);
        pause_rx(16'd0);
        chk("R10 zero time releases", 32'(reg_rdata[6]), 0);

        wr_reg(8'h00);
        pause_rx(16'd4);
        chk("R11 active with enable off", 32'(reg_rdata[6]), 1);
        chk("R11 no inhibit with enable off", 32'(tx_inhibit), 0);
        pause_rx(16'd0);

        wr_reg(8'h20);
        chk("R8 write one clears status", 32'(reg_rdata[5]), 0);
        full_duplex = 1'b0;
        pause_rx(16'd7);
        chk("R8 half duplex pause ignored", 32'(reg_rdata[5]), 0);
        chk("R8 half duplex timer untouched", 32'(reg_rdata[6]), 0);

        full_duplex = 1'b1;
        rd_clr_off = 1'b1;
        pause_rx(16'd0);
        chk("R9 status set", 32'(reg_rdata[5]), 1);
        rd_pulse();
        chk("R9 read kept status when disabled", 32'(reg_rdata[5]), 1);
        rd_clr_off = 1'b0;
        rd_pulse();
        chk("R9 read cleared status", 32'(reg_rdata[5]), 0);

        full_duplex = 1'b0;
        wr_reg(8'h08);
        fill_level = 12'd60;
        frame(1'b0);
        chk("R6 jam above mark", 32'(jam_req), 1);
        cyc(1);
        chk("R6 jam lasts one cycle", 32'(jam_req), 0);
        fill_level = 12'd30;
        frame(1'b0);
        chk("R6 no jam below mark", 32'(jam_req), 0);
        fill_level = 12'd60;
        full_duplex = 1'b1;
        frame(1'b0);
        chk("R6 no jam in full duplex", 32'(jam_req), 0);

        full_duplex = 1'b0;
        wr_reg(8'h10);
        frame(1'b0);
        chk("R7 no jam without match", 32'(jam_req), 0);
        frame(1'b1);
        chk("R7 jam on match", 32'(jam_req), 1);

        cyc(10);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule